// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial command port of a small paged flash device. It runs on a fast system clock and oversamples chip select, serial clock and serial data. It accepts a bus master in either clock-polarity mode where data is captured on the rising serial clock edge. It assembles an instruction byte, then any address and data bytes, and decides what the instruction asks for. When a modify instruction passes its checks, the block sends a one-cycle start strobe to a separate page engine, together with a kind code and an address. That engine performs the erase or program cycle and reports back through a busy level and a completion pulse.

The block keeps two pieces of state: a write-enable flag, which every modify instruction needs, and a sleep flag, which shuts out all instructions except the wake instruction. A status read streams a status byte back for as long as chip select stays low. This works while an engine cycle is running.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: Serial data in is captured on rising serial-clock edges and serial data out changes only after falling edges, so a master idling the clock either low (mode 0) or high (mode 3) gets identical results.
- R2: While chip select is high, `miso_oe` is 0 and the bit and byte framing restarts at the next selection.
- R3: A modify instruction (opcodes 0x0A, 0x02, 0xDB, 0xD8) starts nothing unless chip select rises after a whole number of bytes, that is a clock count that is a multiple of eight.
- R4: A modify instruction starts a cycle only if the write-enable flag is set. The flag is set only by a frame consisting of exactly the byte 0x06.
- R5: Page write (0x0A, kind 0) and page program (0x02, kind 1) need the opcode, three address bytes MSB-first and at least one data byte. Each data byte is presented once on `wr_byte` with a one-cycle `wr_valid`. Page erase (0xDB, kind 2) and sector erase (0xD8, kind 3) need exactly the opcode and three address bytes. An accepted instruction gives one `op_start` pulse with `op_kind` and `op_addr` valid.
- R6: After a frame of exactly the byte 0xB9, every instruction except 0xAB is ignored: no status output, no start and no flag change. An 0xAB opcode ends this state and leaves the write-enable flag as it was.
- R7: `rst_n` low while `busy` is low clears the write-enable flag, the sleep state and the output enable. `rst_n` low while `busy` is high has no effect.
- R8: Opcode 0x05 returns the status byte MSB-first, repeated for as long as chip select stays low. Bit 0 is the `busy` input (write in progress), bit 1 is the write-enable flag, and the other bits are 0. It can be read while `busy` is high.
- R9: A `cycle_done` pulse clears the write-enable flag.
- R10: An unknown opcode is ignored until chip select rises. It gives no output, no start and no flag change.
- R11: A modify instruction is not started while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset, honoured only while busy is low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| busy | input | 1 | Page engine cycle in progress |
| cycle_done | input | 1 | One-cycle pulse when the engine finishes a cycle |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for miso |
| op_start | output | 1 | One-cycle start strobe to the page engine |
| op_kind | output | 2 | 0 page write, 1 page program, 2 page erase, 3 sector erase |
| op_addr | output | 24 | Address captured from the instruction |
| wr_valid | output | 1 | A data byte is present on wr_byte |
| wr_byte | output | 8 | Data byte for the page buffer |

## Verification
The hardest states to reach are the combinations where several conditions for a start meet at one chip-select rise: the flag state, the sleep state, the busy level, the byte count and a trailing partial byte. The bench sweeps every modify opcode in both clock modes over total frame lengths of three to six bytes, each preceded by a write enable and followed by a completion pulse. It then builds the rarer paths explicitly: sleep entered with the flag already set and then woken, a frame three bits past a byte boundary, a start attempt while busy, and a reset pulse during busy.

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend #(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      mosi,
  input  logic                      busy,
  input  logic                      cycle_done,
  output logic                      miso,
  output logic                      miso_oe,
  output logic                      op_start,
  output logic [1:0]                op_kind,
  output logic [8*ADDR_BYTES-1:0]   op_addr,
  output logic                      wr_valid,
  output logic [7:0]                wr_byte
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam logic [CNT_W-1:0] HDR_LEN = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_PW   = 8'h0A;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_PE   = 8'hDB;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_SLP  = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;

  logic [2:0] cs_sy, sk_sy;
  logic [1:0] mo_sy;
  logic [6:0] shreg;
  logic [2:0] bit_cnt, out_idx;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0] opcode;
  logic [ADDR_W-1:0] addr;
  logic wel, dpd, rd_mode;

  wire cs_s     = cs_sy[1];
  wire cs_rise  = cs_sy[1] & ~cs_sy[2];
  wire sck_rise = sk_sy[1] & ~sk_sy[2] & ~cs_s;
  wire sck_fall = ~sk_sy[1] & sk_sy[2] & ~cs_s;
  wire rst_act  = ~rst_n & ~busy;
  wire [7:0] byte_in = {shreg, mo_sy[1]};
  wire [7:0] status  = {6'b0, wel, busy};
  wire is_prog  = (opcode == OP_PW) || (opcode == OP_PP);
  wire is_erase = (opcode == OP_PE) || (opcode == OP_SE);
  wire whole    = (bit_cnt == 3'd0);
  wire len_ok   = is_prog ? (byte_cnt > HDR_LEN) : (byte_cnt == HDR_LEN);
  wire go       = cs_rise && !dpd && whole && wel && !busy && (is_prog || is_erase) && len_ok;

  always_ff @(posedge clk) begin
    if (rst_act) begin
      cs_sy <= 3'b111; sk_sy <= 3'b000; mo_sy <= 2'b00;
      shreg <= '0; bit_cnt <= '0; out_idx <= 3'd7; byte_cnt <= '0;
      opcode <= '0; addr <= '0; wel <= 1'b0; dpd <= 1'b0; rd_mode <= 1'b0;
      miso <= 1'b0; miso_oe <= 1'b0; op_start <= 1'b0; op_kind <= '0;
      op_addr <= '0; wr_valid <= 1'b0; wr_byte <= '0;
    end else begin
      cs_sy <= {cs_sy[1:0], cs_n};
      sk_sy <= {sk_sy[1:0], sclk};
      mo_sy <= {mo_sy[0], mosi};
      op_start <= 1'b0;
      wr_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0; byte_cnt <= '0; rd_mode <= 1'b0;
        miso_oe <= 1'b0; out_idx <= 3'd7;
      end else begin
        if (sck_rise) begin
          shreg <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == '0) begin
              opcode <= byte_in;
              if (byte_in == OP_WAKE) dpd <= 1'b0;
              if (!dpd && byte_in == OP_STAT) rd_mode <= 1'b1;
            end else if (byte_cnt < HDR_LEN) begin
              addr <= {addr[ADDR_W-9:0], byte_in};
            end else if (is_prog && !dpd) begin
              wr_valid <= 1'b1;
              wr_byte <= byte_in;
            end
          end
        end
        if (sck_fall && rd_mode) begin
          miso <= status[out_idx];
          out_idx <= out_idx - 3'd1;
          miso_oe <= 1'b1;
        end
      end
      if (cs_rise && !dpd && whole && byte_cnt == CNT_W'(1)) begin
        if (opcode == OP_WEN) wel <= 1'b1;
        if (opcode == OP_SLP) dpd <= 1'b1;
      end
      if (go) begin
        op_start <= 1'b1;
        op_addr <= addr;
        case (opcode)
          OP_PW:   op_kind <= 2'd0;
          OP_PP:   op_kind <= 2'd1;
          OP_PE:   op_kind <= 2'd2;
          default: op_kind <= 2'd3;
        endcase
      end
      if (cycle_done) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flash_cmd_frontend_chk.sv
module spi_flash_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       miso_oe,
  input logic       op_start,
  input logic       wel,
  input logic       dpd,
  input logic       busy,
  input logic       cycle_done,
  input logic [2:0] bit_cnt
);
  p_oe_off_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);
  p_start_whole_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(bit_cnt) == 3'd0);
  p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wel));
  p_start_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  p_no_start_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(dpd));
  p_done_clears_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !wel);
  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(busy));
endmodule

bind spi_flash_cmd_frontend spi_flash_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .miso_oe(miso_oe), .op_start(op_start),
  .wel(wel), .dpd(dpd), .busy(busy), .cycle_done(cycle_done), .bit_cnt(bit_cnt)
);

// File: tb/spi_flash_cmd_frontend_tb.sv
module spi_flash_cmd_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0, busy = 0, cycle_done = 0;
  logic miso, miso_oe, op_start, wr_valid;
  logic [1:0] op_kind;
  logic [23:0] op_addr;
  logic [7:0] wr_byte;
  int n_cmp = 0, n_bad = 0, starts = 0, wr_cnt = 0, cyc = 0;
  logic [1:0] last_kind;
  logic [23:0] last_addr;
  logic [7:0] last_wr;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  bit oe_seen;
  logic [7:0] ops [4] = '{8'h0A, 8'h02, 8'hDB, 8'hD8};

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
    .cycle_done(cycle_done), .miso(miso), .miso_oe(miso_oe), .op_start(op_start),
    .op_kind(op_kind), .op_addr(op_addr), .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  always @(posedge clk) begin
    if (op_start) begin starts <= starts + 1; last_kind <= op_kind; last_addr <= op_addr; end
    if (wr_valid) begin wr_cnt <= wr_cnt + 1; last_wr <= wr_byte; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input bit m3);
    oe_seen = 0;
    cs_n = 0; ticks(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[i/8][7-(i%8)];
      sclk = 0; ticks(4);
      rx[i/8][7-(i%8)] = miso;
      if (miso_oe) oe_seen = 1;
      sclk = 1; ticks(4);
    end
    if (!m3) sclk = 0;
    ticks(4); cs_n = 1; ticks(8); sclk = m3; ticks(4);
    chk(miso_oe == 1'b0, "R2 oe after deselect", int'(miso_oe), 0);
  endtask

  task automatic cmd1(input logic [7:0] op, input bit m3);
    tx[0] = op; frame(8, m3);
  endtask

  task automatic rdsr(input logic [7:0] exp, input bit m3, input string tag);
    tx[0] = 8'h05; frame(32, m3);
    chk(oe_seen, {tag, " oe during read"}, int'(oe_seen), 1);
    for (int b = 1; b < 4; b++) chk(rx[b] == exp, tag, int'(rx[b]), int'(exp));
  endtask

  task automatic done_pulse;
    cycle_done = 1; ticks(1); cycle_done = 0; ticks(2);
  endtask

  task automatic send_op(input logic [7:0] op, input logic [23:0] a, input int nbytes, input int extra, input bit m3);
    tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
    for (int j = 4; j < 16; j++) tx[j] = 8'hA0 + 8'(j - 4);
    frame(8*nbytes + extra, m3);
  endtask

  initial begin
    int s0, w0;
    ticks(5);
    chk(miso_oe == 1'b0, "R7 reset oe", int'(miso_oe), 0);
    chk(starts == 0, "R7 reset no start", starts, 0);
    rst_n = 1; ticks(3);
    rdsr(8'h00, 0, "R8 idle status mode0");
    rdsr(8'h00, 1, "R1 idle status mode3");
    cmd1(8'h06, 1);
    rdsr(8'h02, 0, "R4 wel set by 0x06");
    busy = 1;
    rdsr(8'h03, 1, "R8 status while busy");
    s0 = starts;
    send_op(8'hDB, 24'h00AB00, 4, 0, 0);
    chk(starts == s0, "R11 no start while busy", starts - s0, 0);
    busy = 0;
    done_pulse();
    rdsr(8'h00, 0, "R9 wel cleared");
    s0 = starts;
    send_op(8'h02, 24'h001234, 5, 0, 0);
    chk(starts == s0, "R4 no start without wel", starts - s0, 0);
    tx[0] = 8'h06; tx[1] = 8'h00; frame(9, 0);
    rdsr(8'h00, 0, "R4 nine-bit enable ignored");

    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++)
        for (int n = 3; n <= 6; n++) begin
          logic [23:0] a;
          bit exp_go;
          int exp_wr;
          a = 24'h100000 + 24'(k*24'h1111) + 24'(m*24'h200) + 24'(n);
          exp_go = (k < 2) ? (n >= 5) : (n == 4);
          exp_wr = (k < 2 && n > 4) ? n - 4 : 0;
          cmd1(8'h06, bit'(m));
          s0 = starts; w0 = wr_cnt;
          send_op(ops[k], a, n, 0, bit'(m));
          chk(starts - s0 == int'(exp_go), "R5 start count", starts - s0, int'(exp_go));
          chk(wr_cnt - w0 == exp_wr, "R5 data byte count", wr_cnt - w0, exp_wr);
          if (exp_go) begin
            chk(last_kind == 2'(k), "R5 kind", int'(last_kind), k);
            chk(last_addr == a, "R5 address", int'(last_addr), int'(a));
          end
          if (exp_wr > 0)
            chk(last_wr == 8'hA0 + 8'(exp_wr - 1), "R5 last data byte", int'(last_wr), int'(8'hA0 + 8'(exp_wr - 1)));
          done_pulse();
          rdsr(8'h00, bit'(m), "R9 wel clear after done");
        end

    cmd1(8'h06, 0);
    s0 = starts;
    send_op(8'h0A, 24'h000300, 5, 3, 0);
    chk(starts == s0, "R3 partial byte rejected", starts - s0, 0);
    s0 = starts;
    send_op(8'hD8, 24'h010000, 4, 5, 1);
    chk(starts == s0, "R3 partial erase rejected", starts - s0, 0);

    s0 = starts;
    tx[0] = 8'h9F; tx[1] = 8'h00; tx[2] = 8'h00; frame(24, 0);
    chk(oe_seen == 0, "R10 unknown no output", int'(oe_seen), 0);
    chk(starts == s0, "R10 unknown no start", starts - s0, 0);
    rdsr(8'h02, 0, "R10 wel unchanged");

    cmd1(8'hB9, 0);
    tx[0] = 8'h05; frame(24, 0);
    chk(oe_seen == 0, "R6 status blocked asleep", int'(oe_seen), 0);
    s0 = starts;
    send_op(8'hDB, 24'h000500, 4, 0, 1);
    chk(starts == s0, "R6 no start asleep", starts - s0, 0);
    cmd1(8'hAB, 0);
    rdsr(8'h02, 0, "R6 awake wel kept");
    s0 = starts;
    send_op(8'hDB, 24'h000500, 4, 0, 0);
    chk(starts - s0 == 1, "R6 start after wake", starts - s0, 1);
    done_pulse();

    cmd1(8'h06, 0);
    busy = 1; rst_n = 0; ticks(4); rst_n = 1; ticks(2);
    rdsr(8'h03, 0, "R7 reset ignored while busy");
    busy = 0; rst_n = 0; ticks(4); rst_n = 1; ticks(2);
    rdsr(8'h00, 0, "R7 reset clears wel");
    cmd1(8'hB9, 1);
    rst_n = 0; ticks(4); rst_n = 1; ticks(2);
    rdsr(8'h00, 1, "R7 reset wakes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule